// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides one 64-bit operand by another, one quotient bit per clock, with a fixed restoring shift-and-subtract loop. A single unit serves both quotient and remainder operations: a flag chosen alongside the start pulse selects which of the two is returned. Two further flags select signed or unsigned arithmetic and full-width or 32-bit operands. In 32-bit mode the operands are narrowed to their low halves, extended to 64 bits according to the signed flag, and then run through the same 64-step loop.

The host pulses `start_i` with operands and flags valid in the same cycle. The unit raises `busy_o` while it works and pulses `done_o` for one cycle when `result_o` holds the answer. Latency does not depend on the operands or the mode, so a scheduler can count on it. The result stays on `result_o` until the next accepted start.

Top module: `int_divider`

## Requirements
- R1: A start accepted on a rising edge (with `busy_o` low) makes `done_o` high during the cycle that follows the 64th rising edge after it, for every operand value and every combination of flags, 32-bit mode included.
- R2: `done_o` is high for exactly one cycle per accepted start.
- R3: A start pulse while `busy_o` is high is ignored: the running operation keeps its operands, flags and latency, and no extra `done_o` pulse follows.
- R4: With `is_signed_i`=0, `is_32bit_i`=0 and `want_rem_i`=0, the result is the unsigned quotient floor(dividend/divisor).
- R5: With `is_signed_i`=0, `is_32bit_i`=0 and `want_rem_i`=1, the result is the unsigned remainder.
- R6: With `is_signed_i`=1 and `want_rem_i`=0, operand magnitudes are divided and the quotient is negated (two's complement) when the operand signs differ; the most negative dividend over -1 yields bit pattern 0x8000_0000_0000_0000.
- R7: With `is_signed_i`=1 and `want_rem_i`=1, the remainder has the magnitude of the unsigned remainder of the magnitudes and the sign of the dividend.
- R8: With `is_32bit_i`=1, only bits 31:0 of each operand are used, sign-extended to 64 bits when `is_signed_i`=1 and zero-extended otherwise; bits 63:32 of the inputs have no effect.
- R9: A divisor of zero (after the 32-bit narrowing) gives `result_o`=0 with the normal latency.
- R10: `result_o` is held unchanged from the `done_o` cycle until the next accepted start.
- R11: After reset `busy_o`=0, `done_o`=0 and `result_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| dividend_i | input | 64 | Dividend |
| divisor_i | input | 64 | Divisor |
| is_signed_i | input | 1 | 1: two's complement operands |
| is_32bit_i | input | 1 | 1: use low 32 bits of each operand |
| want_rem_i | input | 1 | 1: return remainder, 0: return quotient |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | 64 | Quotient or remainder |

## Verification
The hardest situation to reach is a start request that lands in the middle of a running division, since a well-behaved host never issues one. The bench raises `start_i` with different operands and flags on the tenth cycle of an operation, then checks that the first operation's result and latency are unchanged and that no second `done_o` pulse arrives in the following stretch. Signed overflow (most negative over -1) and a divisor whose only set bits sit above bit 31 in 32-bit mode are driven explicitly, since random operands almost never hit them.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef struct packed {
    logic is_signed;
    logic is_32bit;
    logic want_rem;
  } div_op_t;
endpackage

// File: rtl/div_prep.sv
module div_prep
  import div_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  div_op_t      op_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_quo_o,
  output logic         neg_rem_o,
  output logic         zero_o
);
  localparam int HW = W / 2;

  logic [W-1:0] ext_a, ext_b;
  logic         sgn_a, sgn_b;

  always_comb begin
    if (op_i.is_32bit) begin
      ext_a = {{HW{op_i.is_signed & a_i[HW-1]}}, a_i[HW-1:0]};
      ext_b = {{HW{op_i.is_signed & b_i[HW-1]}}, b_i[HW-1:0]};
    end else begin
      ext_a = a_i;
      ext_b = b_i;
    end
    sgn_a     = op_i.is_signed & ext_a[W-1];
    sgn_b     = op_i.is_signed & ext_b[W-1];
    mag_a_o   = sgn_a ? (~ext_a + 1'b1) : ext_a;
    mag_b_o   = sgn_b ? (~ext_b + 1'b1) : ext_b;
    neg_quo_o = sgn_a ^ sgn_b;
    neg_rem_o = sgn_a;
    zero_o    = (ext_b == '0);
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0]   shifted;
  logic [W-1:0] diff;
  logic         fits;

  always_comb begin
    shifted = {rem_i, quo_i[W-1]};
    fits    = (shifted >= {1'b0, den_i});
    diff    = shifted[W-1:0] - den_i;   // low bits exact when fits
    rem_o   = fits ? diff : shifted[W-1:0];
    quo_o   = {quo_i[W-2:0], fits};
  end
endmodule

// File: rtl/div_fix.sv
module div_fix #(
  parameter int W = 64
) (
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] rem_i,
  input  logic         want_rem_i,
  input  logic         neg_quo_i,
  input  logic         neg_rem_i,
  input  logic         zero_i,
  output logic [W-1:0] result_o
);
  logic [W-1:0] sel;
  logic         neg;

  always_comb begin
    sel = want_rem_i ? rem_i : quo_i;
    neg = want_rem_i ? neg_rem_i : neg_quo_i;
    if (zero_i)   result_o = '0;
    else if (neg) result_o = ~sel + 1'b1;
    else          result_o = sel;
  end
endmodule

// File: rtl/int_divider.sv
module int_divider
  import div_pkg::*;
#(
  parameter int W      = 64,
  parameter int CYCLES = W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  input  logic         is_signed_i,
  input  logic         is_32bit_i,
  input  logic         want_rem_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  div_op_t      op_in;
  logic [W-1:0] mag_a, mag_b;
  logic         neg_quo_d, neg_rem_d, zero_d;

  logic [W-1:0] rem_q, quo_q, den_q, res_q;
  logic [W-1:0] rem_n, quo_n, res_n;
  logic [CNT_W-1:0] cnt_q;
  logic busy_q, done_q;
  logic want_rem_q, neg_quo_q, neg_rem_q, zero_q;
  logic accept, last_step;

  assign op_in     = '{is_signed: is_signed_i, is_32bit: is_32bit_i, want_rem: want_rem_i};
  assign accept    = start_i & ~busy_q;
  assign last_step = busy_q & (cnt_q == LAST);

  div_prep #(.W(W)) u_prep (
    .a_i(dividend_i), .b_i(divisor_i), .op_i(op_in),
    .mag_a_o(mag_a), .mag_b_o(mag_b),
    .neg_quo_o(neg_quo_d), .neg_rem_o(neg_rem_d), .zero_o(zero_d)
  );

  div_step #(.W(W)) u_step (
    .rem_i(rem_q), .quo_i(quo_q), .den_i(den_q),
    .rem_o(rem_n), .quo_o(quo_n)
  );

  div_fix #(.W(W)) u_fix (
    .quo_i(quo_n), .rem_i(rem_n), .want_rem_i(want_rem_q),
    .neg_quo_i(neg_quo_q), .neg_rem_i(neg_rem_q), .zero_i(zero_q),
    .result_o(res_n)
  );

  // operand capture on accept, one restoring step per busy cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q      <= '0;
      quo_q      <= '0;
      den_q      <= '0;
      want_rem_q <= 1'b0;
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      zero_q     <= 1'b0;
    end else if (accept) begin
      rem_q      <= '0;
      quo_q      <= mag_a;
      den_q      <= mag_b;
      want_rem_q <= want_rem_i;
      neg_quo_q  <= neg_quo_d;
      neg_rem_q  <= neg_rem_d;
      zero_q     <= zero_d;
    end else if (busy_q) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      res_q  <= '0;
    end else begin
      done_q <= last_step;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_step) begin
          busy_q <= 1'b0;
          res_q  <= res_n;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;

  // independent latency watch for the assertion below
  logic [CNT_W:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= '0;
    else if (accept)  lat_q <= '0;
    else if (busy_o && lat_q <= (CNT_W+1)'(CYCLES)) lat_q <= lat_q + 1'b1;
  end

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == (CNT_W+1)'(CYCLES)));

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_start_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(den_q) && $stable(want_rem_q) && $stable(zero_q)));

  assert_rem_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ((den_q == '0) || (rem_q < den_q)));

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(result_o));
endmodule

// File: tb/sim_int_divider.sv
module sim_int_divider;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] dividend_i = '0;
  logic [63:0] divisor_i = '0;
  logic        is_signed_i = 1'b0;
  logic        is_32bit_i = 1'b0;
  logic        want_rem_i = 1'b0;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // accept edge plus 64 steps: done seen on the 65th falling edge after start is driven
  localparam int EXP_LAT = 65;

  always #5 clk_i = ~clk_i;

  int_divider u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .is_signed_i(is_signed_i), .is_32bit_i(is_32bit_i), .want_rem_i(want_rem_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic s, input logic w, input logic r);
    logic [63:0] ea, eb, ma, mb, q, m;
    logic na, nb;
    ea = a; eb = b;
    if (w) begin
      ea = {(s && a[31]) ? 32'hFFFF_FFFF : 32'h0, a[31:0]};
      eb = {(s && b[31]) ? 32'hFFFF_FFFF : 32'h0, b[31:0]};
    end
    if (eb == 64'd0) return 64'd0;
    na = s && ea[63];
    nb = s && eb[63];
    ma = na ? (64'd0 - ea) : ea;
    mb = nb ? (64'd0 - eb) : eb;
    q = ma / mb;
    m = ma % mb;
    if (r) return na ? (64'd0 - m) : m;
    return (na != nb) ? (64'd0 - q) : q;
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b,
                       input logic s, input logic w, input logic r);
    dividend_i = a; divisor_i = b;
    is_signed_i = s; is_32bit_i = w; want_rem_i = r;
  endtask

  // runs one op; optional intrusive start at cycle poke_at (0 = none)
  task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                        input logic s, input logic w, input logic r, input int poke_at);
    int lat;
    @(negedge clk_i);
    drive(a, b, s, w, r);
    start_i = 1'b1;
    lat = 0;
    do begin
      @(negedge clk_i);
      lat++;
      start_i = 1'b0;
      if (poke_at != 0 && lat == poke_at) begin
        drive(~a, b + 64'd3, ~s, ~w, ~r);
        start_i = 1'b1;
      end
    end while (!done_o && lat < 200);
    check(req, result_o, model(a, b, s, w, r));
    check("R1", 64'(lat), 64'(EXP_LAT));
    @(negedge clk_i);
    check("R2", {63'd0, done_o}, 64'd0);
  endtask

  task automatic t_reset();
    check("R11", {62'd0, busy_o, done_o}, 64'd0);
    check("R11", result_o, 64'd0);
  endtask

  task automatic t_unsigned();
    run_op("R4", 64'd100, 64'd7, 1'b0, 1'b0, 1'b0, 0);
    run_op("R5", 64'd100, 64'd7, 1'b0, 1'b0, 1'b1, 0);
    run_op("R4", 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 1'b0, 1'b0, 1'b0, 0);
    run_op("R5", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0001, 1'b0, 1'b0, 1'b1, 0);
    run_op("R4", 64'd5, 64'd9, 1'b0, 1'b0, 1'b0, 0);
    run_op("R5", 64'd5, 64'd9, 1'b0, 1'b0, 1'b1, 0);
    run_op("R4", 64'h8000_0000_0000_0000, 64'd1, 1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic t_signed();
    run_op("R6", -64'sd100, 64'd7, 1'b1, 1'b0, 1'b0, 0);
    run_op("R6", 64'd100, -64'sd7, 1'b1, 1'b0, 1'b0, 0);
    run_op("R6", -64'sd100, -64'sd7, 1'b1, 1'b0, 1'b0, 0);
    run_op("R7", -64'sd100, 64'd7, 1'b1, 1'b0, 1'b1, 0);
    run_op("R7", 64'd100, -64'sd7, 1'b1, 1'b0, 1'b1, 0);
    run_op("R7", -64'sd100, -64'sd7, 1'b1, 1'b0, 1'b1, 0);
    run_op("R6", 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 0);
    check("R6", result_o, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_32bit();
    run_op("R8", 64'hDEAD_BEEF_FFFF_FF9C, 64'h1234_5678_0000_0007, 1'b1, 1'b1, 1'b0, 0);
    check("R8", result_o, 64'hFFFF_FFFF_FFFF_FFF2);
    run_op("R8", 64'hDEAD_BEEF_FFFF_FF9C, 64'h1234_5678_0000_0007, 1'b0, 1'b1, 1'b0, 0);
    run_op("R8", 64'hDEAD_BEEF_FFFF_FF9C, 64'h1234_5678_0000_0007, 1'b1, 1'b1, 1'b1, 0);
    run_op("R8", 64'h0000_0001_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 0);
  endtask

  task automatic t_divzero();
    run_op("R9", 64'd123, 64'd0, 1'b0, 1'b0, 1'b0, 0);
    run_op("R9", 64'd123, 64'd0, 1'b0, 1'b0, 1'b1, 0);
    run_op("R9", -64'sd5, 64'd0, 1'b1, 1'b0, 1'b1, 0);
    run_op("R9", 64'd77, 64'hABCD_0000_0000, 1'b1, 1'b1, 1'b0, 0);
    check("R9", result_o, 64'd0);
  endtask

  task automatic t_busy_start();
    int extra;
    run_op("R3", 64'd1000, 64'd33, 1'b0, 1'b0, 1'b0, 10);
    extra = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk_i);
      if (done_o) extra++;
    end
    check("R3", 64'(extra), 64'd0);
    run_op("R3", -64'sd999, 64'd10, 1'b1, 1'b0, 1'b1, 30);
  endtask

  task automatic t_hold();
    logic [63:0] held;
    run_op("R5", 64'd4242, 64'd100, 1'b0, 1'b0, 1'b1, 0);
    held = result_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      drive(64'(i * 97 + 1), 64'(i + 2), i[0], i[1], ~i[0]);
    end
    check("R10", result_o, held);
    check("R10", result_o, 64'd42);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<=150000", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_unsigned();
    t_signed();
    t_32bit();
    t_divzero();
    t_busy_start();
    t_hold();
    repeat (3) @(negedge clk_i);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule